// File: doc/BRIEF.md
# Memory Header Checksum Engine

This block computes a 16-bit checksum over a run of bytes held in a byte-addressed memory. A controller pulses `start` with a base address and a byte count. The engine then reads the bytes one at a time through a read port, pairs them into 16-bit words, and folds each word into a running checksum. When the last word has been folded in, `done` pulses and `result` holds the checksum. A configuration header is a typical use: the region runs from offset 0 with 248 bytes, and the caller stores the 16-bit result high byte first at offset 0xFC. Storing the result is the caller's job.

The read request is a valid/ready channel. `rd_req_valid` and `rd_req_addr` stay asserted and unchanged until the memory takes the request with `rd_req_ready`. Only one request is open at a time. The response channel has no back-pressure: the engine always accepts `rd_rsp_valid`, and the memory may answer any number of cycles after it accepted the request. `start`, `busy` and `done` are plain control pins.

Top module: `nvcrc_engine`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req_valid` are 0 and `result` is 0xFFFF.
- R2: An accepted `start` latches `start_addr` and `byte_count`. The engine issues exactly `byte_count` single-byte reads at ascending addresses, beginning at `start_addr`. While `rd_req_valid` is high and `rd_req_ready` is low, the request address does not change.
- R3: At most one read is open at a time. After a request handshake, `rd_req_valid` stays low until the response arrives.
- R4: Bytes are paired into words as (byte at lower address << 8) | byte at next address.
- R5: The checksum starts at 0xFFFF. Each word w updates the checksum c as follows. Let p = c ^ w, a = p[3:0] and b = p[7:4] ^ a. Then c' = (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12), truncated to 16 bits.
- R6: When the byte count is odd, the last byte becomes a word with that byte in bits 15:8 and zero in bits 7:0, and this word takes one more update. For example, a single byte 0x00 gives 0x0F87.
- R7: `done` is high for exactly one cycle, in the same cycle that `result` first shows the final value. After that, `result` stays unchanged until the next accepted `start`.
- R8: A `start` pulse while `busy` is high is ignored. The running computation keeps its addresses, its count and its result.
- R9: A `byte_count` of 0 issues no reads. `done` pulses on the cycle after `start`, with `result` equal to 0xFFFF.
- R10: The standard header run of 248 bytes from address 0 gives the checksum defined by R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; accepted only while idle |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to cover |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Checksum value |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the request |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data byte |

## Verification
An address counter that is off by one, or that moves without a handshake, shows at the request port on the next accepted read. It shows as a skipped, repeated or wrong address, and the bench checks every address against a model of the run. A pairing register that is out of step swaps the high and low bytes of a word or drops the padding. Since every update after that point mixes in the error, `result` is wrong when `done` rises. A count that fails to end the run shows as a missing or late `done`, or as a surplus read. The bench counts every read, so it catches this in the first run it affects.

// File: rtl/nvcrc_pkg.sv
package nvcrc_pkg;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // one nibble-folded update of the running checksum with a 16-bit word
  function automatic logic [15:0] nvcrc_step(input logic [15:0] prev, input logic [15:0] word);
    logic [15:0] mix;
    logic [15:0] lo;
    logic [15:0] fold;
    mix  = prev ^ word;
    lo   = {12'h000, mix[3:0]};
    fold = {12'h000, mix[7:4] ^ mix[3:0]};
    return (prev >> 8) ^ (lo << 3) ^ (lo << 8) ^ fold ^ (fold << 7) ^ (fold << 12);
  endfunction
endpackage

// File: rtl/nvcrc_fetch.sv
module nvcrc_fetch #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  total,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              byte_last
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  issue_left;
  logic [CNT_W-1:0]  recv_left;
  logic              open_q;
  logic              run_q;
  logic              take_req;
  logic              take_rsp;

  assign req_valid  = run_q && !open_q && (issue_left != '0);
  assign req_addr   = addr_q;
  assign take_req   = req_valid && req_ready;
  assign take_rsp   = rsp_valid && open_q;
  assign byte_valid = take_rsp;
  assign byte_data  = rsp_data;
  assign byte_last  = (recv_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      issue_left <= '0;
      recv_left  <= '0;
      open_q     <= 1'b0;
      run_q      <= 1'b0;
    end else if (launch) begin
      addr_q     <= base_addr;
      issue_left <= total;
      recv_left  <= total;
      open_q     <= 1'b0;
      run_q      <= (total != '0);
    end else begin
      if (take_req) begin
        addr_q     <= addr_q + ADDR_W'(1);
        issue_left <= issue_left - CNT_W'(1);
        open_q     <= 1'b1;
      end
      if (take_rsp) begin
        open_q    <= 1'b0;
        recv_left <= recv_left - CNT_W'(1);
        if (byte_last) run_q <= 1'b0;
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !launch) |=> (req_valid && $stable(req_addr)));
  // R3
  one_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !launch) |=> !req_valid);
endmodule

// File: rtl/nvcrc_pack.sv
module nvcrc_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        byte_last,
  output logic        word_valid,
  output logic [15:0] word_data,
  output logic        word_last
);
  logic [7:0] hi_q;
  logic       have_hi;

  assign word_valid = byte_valid && (have_hi || byte_last);
  assign word_data  = have_hi ? {hi_q, byte_data} : {byte_data, 8'h00};
  assign word_last  = byte_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hi_q    <= '0;
      have_hi <= 1'b0;
    end else if (byte_valid) begin
      if (have_hi) begin
        have_hi <= 1'b0;
      end else if (!byte_last) begin
        hi_q    <= byte_data;
        have_hi <= 1'b1;
      end
    end
  end

  // R6
  pair_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_last) |=> !have_hi);
  // R4
  pair_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_last && !have_hi && !clear) |=> (have_hi && hi_q == $past(byte_data)));
endmodule

// File: rtl/nvcrc_accum.sv
module nvcrc_accum
  import nvcrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        finish_empty,
  input  logic        word_valid,
  input  logic [15:0] word_data,
  input  logic        word_last,
  output logic [15:0] crc,
  output logic        done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc  <= CRC_SEED;
      done <= 1'b0;
    end else begin
      done <= (word_valid && word_last) || finish_empty;
      if (clear)           crc <= CRC_SEED;
      else if (word_valid) crc <= nvcrc_step(crc, word_data);
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && !clear) |=> $stable(crc));
endmodule

// File: rtl/nvcrc_engine.sv
module nvcrc_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              busy,
  output logic              done,
  output logic [15:0]       result,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data
);
  logic        launch;
  logic        empty_run;
  logic        b_valid;
  logic [7:0]  b_data;
  logic        b_last;
  logic        w_valid;
  logic [15:0] w_data;
  logic        w_last;
  logic        busy_q;

  assign launch    = start && !busy_q;
  assign empty_run = launch && (byte_count == '0);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 busy_q <= 1'b0;
    else if (launch)            busy_q <= (byte_count != '0);
    else if (w_valid && w_last) busy_q <= 1'b0;
  end

  nvcrc_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .base_addr(start_addr), .total(byte_count),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .byte_valid(b_valid), .byte_data(b_data), .byte_last(b_last)
  );

  nvcrc_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clear(launch),
    .byte_valid(b_valid), .byte_data(b_data), .byte_last(b_last),
    .word_valid(w_valid), .word_data(w_data), .word_last(w_last)
  );

  nvcrc_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clear(launch), .finish_empty(empty_run),
    .word_valid(w_valid), .word_data(w_data), .word_last(w_last),
    .crc(result), .done(done)
  );

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(rd_req_valid && rd_req_ready)) |=> $stable(rd_req_addr));
  // R9
  empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> (done && result == 16'hFFFF && !rd_req_valid));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid);
endmodule

// File: tb/sim_nvcrc_engine.sv
module sim_nvcrc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 17;
  localparam int NVEC = 6;
  // {start address, byte count}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'd248}, {16'h0010, 16'd2}, {16'h0021, 16'd5},
    {16'h0100, 16'd1},   {16'h0033, 16'd16}, {16'h03F0, 16'd15}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic busy, done;
  logic [15:0] result;
  logic rd_req_valid, rd_req_ready = 0;
  logic [AW-1:0] rd_req_addr;
  logic rd_rsp_valid = 0;
  logic [7:0] rd_rsp_data = 0;

  int checks = 0, fails = 0, cycles = 0;
  int nreq = 0, addr_err = 0, open_err = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0] mem [1024];
  logic pend = 0;
  logic [9:0] paddr = '0;
  int dly = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic finished = 0;

  nvcrc_engine #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .result(result),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] p, a, b;
    p = c ^ w;
    a = {12'h0, p[3:0]};
    b = {12'h0, p[7:4] ^ p[3:0]};
    return (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  function automatic logic [15:0] ref_crc(input int a, input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i + 1 < n; i += 2) c = ref_step(c, {mem[a+i], mem[a+i+1]});
    if (n % 2 == 1) c = ref_step(c, {mem[a+n-1], 8'h00});
    return c;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // memory model: random ready, random response latency
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0;
      rd_rsp_valid <= 0;
      rd_req_ready <= 0;
    end else begin
      if (pend && dly == 0) begin
        rd_rsp_valid <= 1;
        rd_rsp_data  <= mem[paddr];
        pend = 0;
      end else begin
        rd_rsp_valid <= 0;
        if (pend) dly--;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rd_req_valid && (lfsr[0] | lfsr[3])) begin
        if (pend) open_err++;
        if (rd_req_addr != exp_addr) addr_err++;
        exp_addr = exp_addr + 1;
        nreq++;
        pend = 1;
        paddr = rd_req_addr[9:0];
        dly = int'(lfsr[5:4]);
        rd_req_ready <= 1;
      end else begin
        rd_req_ready <= 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic launch_run(input int a, input int n);
    @(negedge clk);
    start = 1; start_addr = AW'(a); byte_count = CW'(n);
    exp_addr = AW'(a); nreq = 0; addr_err = 0; open_err = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 0;
    for (int k = 0; k < 8000 && !seen; k++) begin
      if (done) seen = 1; else @(negedge clk);
    end
  endtask

  task automatic finish_checks(input int a, input int n, input string tag);
    logic seen;
    logic [15:0] exp, held;
    exp = ref_crc(a, n);
    wait_done(seen);
    check(seen, {tag, " R7 done"}, int'(seen), 1);
    check(result == exp, {tag, " R5 R4 result"}, int'(result), int'(exp));
    check(nreq == n && addr_err == 0, {tag, " R2 reads"}, nreq, n);
    check(open_err == 0, {tag, " R3 single open"}, open_err, 0);
    held = result;
    @(negedge clk);
    check(!done && !busy, {tag, " R7 pulse"}, int'(done), 0);
    repeat (4) @(negedge clk);
    check(result == held, {tag, " R7 hold"}, int'(result), int'(held));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 29 + 7) ^ (i >> 3));
    mem[10'h200] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !rd_req_valid && result == 16'hFFFF, "R1 reset", int'(result), 16'hFFFF);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      launch_run(int'(VEC[v][31:16]), int'(VEC[v][15:0]));
      finish_checks(int'(VEC[v][31:16]), int'(VEC[v][15:0]), (v == 0) ? "R10 header" : "R4 vector");
    end

    // R6 single zero byte, hand value
    launch_run(16'h200, 1);
    finish_checks(16'h200, 1, "R6 odd");
    check(result == 16'h0F87, "R6 known value", int'(result), 16'h0F87);

    // R9 zero count
    nreq = 0;
    @(negedge clk);
    start = 1; start_addr = 16'h0055; byte_count = '0;
    @(negedge clk);
    start = 0;
    check(done && result == 16'hFFFF, "R9 empty done", int'(result), 16'hFFFF);
    repeat (5) @(negedge clk);
    check(nreq == 0, "R9 no reads", nreq, 0);

    // R8 start while busy
    launch_run(16'h0040, 10);
    repeat (3) @(negedge clk);
    check(busy, "R8 busy", int'(busy), 1);
    start = 1; start_addr = 16'h0080; byte_count = CW'(3);
    @(negedge clk);
    start = 0;
    finish_checks(16'h0040, 10, "R8 ignored");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule